// File: doc/BRIEF.md
# UART Host Register File with Character Buffers

This block is the byte-wide register front end of a classic asynchronous serial port. A host reaches eight byte offsets with single-cycle read and write strobes. Offsets 0 and 1 are shared: the top bit of the line-control byte selects whether they address the data path and interrupt-enable byte or the two halves of the baud divisor. The block holds the transmit and receive character buffers. Their depth is either one entry or `FIFO_DEPTH` entries, chosen by a bit in the buffer-control byte. It also holds the line-status and modem-status bytes and applies every side effect that a host read or write has on them.

A receiver delivers characters through a one-cycle push strobe, together with three error flags. The flags are stored beside the character and reach the line-status byte only once that character is at the head of the receive buffer. A serializer drains the transmit buffer through a pop strobe and reports whether its shifter is idle. Interrupt arbitration lives outside the block and supplies only the four-bit identity code that the host sees.

Top module: `uart_regs`

## Requirements
- R1: When `lcr_o[7]` is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte (`divisor_o` = {high, low}). The receive/transmit path and the interrupt-enable byte are left untouched. When the bit is 0, offset 1 is the interrupt-enable byte and only its four low bits are kept.
- R2: After reset the line-control byte is 0x03, the line-status byte is 0x60 (holding-empty bit 5 and shifter-empty bit 6 set), both buffers are empty, buffer mode is one-deep, and the divisor and interrupt-enable byte are zero.
- R3: Buffer depth is `FIFO_DEPTH` when bit 0 of a write to offset 2 is 1, and one entry otherwise. A write to offset 2 that changes bit 0 empties both buffers and clears data-ready.
- R4: A write to offset 2 with bit 1 set empties the receive buffer and clears data-ready (line-status bit 0). With bit 2 set it empties the transmit buffer. Bits 7:6 of that write appear on `rx_trig_o`.
- R5: A write to offset 0 (with `lcr_o[7]` = 0) queues the byte and clears line-status bits 5 and 6. When the transmit buffer is full, the write replaces the entry at the write position and the entry count is unchanged.
- R6: A receive push into a full buffer is dropped and sets overrun (bit 1) and the error summary (bit 7). Every push sets data-ready (bit 0).
- R7: A read of offset 5 returns the line-status byte and afterwards clears bits 1, 2, 3, 4 and 7. A read of offset 6 returns the modem-status byte (the OR of all `msr_set` pulses since the last such read) and afterwards clears it.
- R8: A read of offset 2 returns 0xC0 ORed with `irq_id`.
- R9: A read of offset 0 (with `lcr_o[7]` = 0) returns the oldest received character and removes it. It returns 0 when the buffer is empty. Data-ready then shows whether characters remain, and `rx_read` is high during every such read.
- R10: While the receive buffer is non-empty, the head entry's flags (bit 2 break, bit 1 framing, bit 0 parity) are ORed into line-status bits 4, 3 and 2, with bit 7 set if any flag is set. The flags are then cleared in that entry, so after a line-status read they do not come back.
- R11: Offset 7 is a plain read/write byte, and offset 4 keeps the five low bits written. Writes to offsets 5 and 6 have no effect.
- R12: Line-status bit 5 is set whenever the transmit buffer becomes empty. Bit 6 is set only when the buffer is empty and `tx_idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; side effects take place at the clock edge |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| rx_push | input | 1 | Receiver delivers one character |
| rx_char | input | 8 | Received character |
| rx_err | input | 3 | Flags for the character: {break, framing, parity} |
| rx_level | output | clog2(FIFO_DEPTH)+1 | Receive buffer fill count |
| rx_read | output | 1 | Host is reading the receive data; restarts the character timer |
| tx_pop | input | 1 | Serializer takes the head transmit byte |
| tx_idle | input | 1 | Serializer shifter is idle |
| tx_data | output | 8 | Head transmit byte |
| tx_avail | output | 1 | Transmit buffer is non-empty |
| irq_id | input | 4 | Interrupt identity from the external arbiter |
| msr_set | input | 8 | Modem-status bits to set |
| lsr_o | output | 8 | Line-status byte |
| ier_o | output | 4 | Interrupt-enable bits |
| lcr_o | output | 8 | Line-control byte |
| mcr_o | output | 5 | Modem-control bits |
| divisor_o | output | 16 | Baud divisor |
| fifo_en_o | output | 1 | Deep-buffer mode |
| rx_trig_o | output | 2 | Receive trigger level selection |

## Verification
On every cycle, the assertions check the following:
- the buffer count stays within the active depth;
- a push that is dropped leaves the count unchanged, and a transmit overwrite does the same;
- data-ready follows every push;
- a transmit write clears both empty flags;
- a line-status or modem-status read clears the bits it should;
- a receive flush empties the buffer;
- a divisor write leaves the interrupt-enable byte alone.

Only the bench scenarios show that characters come out in order, that depth follows the mode bit, that a mode change flushes both buffers, that head flags merge only after they reach the head and never return once read, and that the read values at each offset are correct.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DATA    = 3'd0,
    OFS_IEN     = 3'd1,
    OFS_IDENT   = 3'd2,
    OFS_LINE    = 3'd3,
    OFS_MODEM   = 3'd4,
    OFS_LSTAT   = 3'd5,
    OFS_MSTAT   = 3'd6,
    OFS_SCRATCH = 3'd7
  } ofs_e;

  // line-status bit positions (software decodes these)
  localparam int LS_DR   = 0;
  localparam int LS_OE   = 1;
  localparam int LS_PE   = 2;
  localparam int LS_FE   = 3;
  localparam int LS_BI   = 4;
  localparam int LS_THRE = 5;
  localparam int LS_TEMT = 6;
  localparam int LS_ERR  = 7;

  // buffer-control write bits
  localparam int BC_EN    = 0;
  localparam int BC_RXRST = 1;
  localparam int BC_TXRST = 2;

  localparam logic [BYTE_W-1:0] LINE_RESET = 8'h03;
  localparam int IEN_W   = 4;
  localparam int MODEM_W = 5;
  localparam int DLAB    = 7;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_flags_t;

endpackage

// File: rtl/uart_regs_fifo.sv
module uart_regs_fifo #(
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter bit OVERWRITE = 1'b0,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deep,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic          hd_clr,
  input  logic [DW-1:0] hd_mask,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nx,
  output logic          full
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d, last, wr_inc, rd_inc;
  logic [CW-1:0] count_q, count_d, limit;
  logic          is_empty, put_new, put_over, take;

  assign limit    = deep ? CW'(DEPTH) : CW'(1);
  assign last     = PW'(limit - CW'(1));
  assign full     = (count_q == limit);
  assign is_empty = (count_q == '0);

  assign put_new  = push && !full && !flush;
  assign put_over = push && full && OVERWRITE && !flush;
  assign take     = pop && !is_empty && !flush;

  assign wr_inc = (wr_q == last) ? '0 : wr_q + PW'(1);
  assign rd_inc = (rd_q == last) ? '0 : rd_q + PW'(1);

  always_comb begin
    if (flush) begin
      wr_d    = '0;
      rd_d    = '0;
      count_d = '0;
    end else begin
      wr_d    = put_new ? wr_inc : wr_q;
      rd_d    = take ? rd_inc : rd_q;
      count_d = count_q + CW'(put_new) - CW'(take);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      count_q <= count_d;
    end
  end

  // storage: a new or overwriting entry lands at the write position,
  // otherwise the head entry may have its side bits cleared
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if ((put_new || put_over) && wr_q == PW'(i))
        mem[i] <= wdata;
      else if (hd_clr && !is_empty && !flush && rd_q == PW'(i))
        mem[i] <= mem[i] & hd_mask;
    end
  end

  assign head     = mem[rd_q];
  assign count    = count_q;
  assign count_nx = count_d;

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= limit);

  p_drop_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !OVERWRITE && !pop && !flush) |=> count_q == $past(count_q));

endmodule

// File: rtl/uart_regs_lsr.sv
module uart_regs_lsr
  import uart_regs_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_lsr,
  input  logic              rx_push,
  input  logic              rx_drop,
  input  logic              rx_flush,
  input  logic [CW-1:0]     rx_cnt_nx,
  input  logic              rx_head_valid,
  input  rx_flags_t         rx_head_err,
  input  logic              tx_write,
  input  logic [CW-1:0]     tx_cnt_nx,
  input  logic              tx_idle,
  output logic [BYTE_W-1:0] lsr_o
);

  logic [BYTE_W-1:0] lsr_q, lsr_d;
  rx_flags_t         merge;
  logic              keep, tx_empty_nx;

  assign merge       = rx_head_valid ? rx_head_err : '0;
  assign keep        = !rd_lsr;
  assign tx_empty_nx = (tx_cnt_nx == '0);

  always_comb begin
    lsr_d = lsr_q;
    if (rx_flush)     lsr_d[LS_DR] = 1'b0;
    else if (rx_push) lsr_d[LS_DR] = 1'b1;
    else              lsr_d[LS_DR] = lsr_q[LS_DR] && (rx_cnt_nx != '0);
    lsr_d[LS_OE]   = (lsr_q[LS_OE] && keep) || rx_drop;
    lsr_d[LS_PE]   = (lsr_q[LS_PE] && keep) || merge.par;
    lsr_d[LS_FE]   = (lsr_q[LS_FE] && keep) || merge.frm;
    lsr_d[LS_BI]   = (lsr_q[LS_BI] && keep) || merge.brk;
    lsr_d[LS_ERR]  = (lsr_q[LS_ERR] && keep) || rx_drop || (|merge);
    lsr_d[LS_THRE] = !tx_write && tx_empty_nx;
    lsr_d[LS_TEMT] = !tx_write && tx_empty_nx && tx_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lsr_q <= 8'h60;
    else        lsr_q <= lsr_d;
  end

  assign lsr_o = lsr_q;

  p_dr_on_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_flush) |=> lsr_q[LS_DR]);

  p_tx_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_write |=> (!lsr_q[LS_THRE] && !lsr_q[LS_TEMT]));

  p_lsr_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !rx_drop && !rx_head_valid) |=> (lsr_q[4:1] == 4'b0 && !lsr_q[LS_ERR]));

endmodule

// File: rtl/uart_regs.sv
module uart_regs
  import uart_regs_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [2:0]    host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          rx_push,
  input  logic [7:0]    rx_char,
  input  logic [2:0]    rx_err,
  output logic [CW-1:0] rx_level,
  output logic          rx_read,
  input  logic          tx_pop,
  input  logic          tx_idle,
  output logic [7:0]    tx_data,
  output logic          tx_avail,
  input  logic [3:0]    irq_id,
  input  logic [7:0]    msr_set,
  output logic [7:0]    lsr_o,
  output logic [3:0]    ier_o,
  output logic [7:0]    lcr_o,
  output logic [4:0]    mcr_o,
  output logic [15:0]   divisor_o,
  output logic          fifo_en_o,
  output logic [1:0]    rx_trig_o
);

  localparam int RXW = BYTE_W + $bits(rx_flags_t);

  logic [BYTE_W-1:0]  dll_q, dlm_q, lcr_q, scr_q, msr_q, msr_d;
  logic [IEN_W-1:0]   ier_q;
  logic [MODEM_W-1:0] mcr_q;
  logic               fen_q;
  logic [1:0]         trig_q;

  logic dlab, wr_data, wr_dll, wr_dlm, wr_ier, wr_bc, wr_lcr, wr_mcr, wr_scr;
  logic rd_data, rd_lsr, rd_msr, mode_chg, rx_flush, tx_flush;
  logic rx_push_eff, rx_drop, rx_full, tx_full;

  logic [RXW-1:0]    rx_head;
  logic [BYTE_W-1:0] tx_head;
  logic [CW-1:0]     rx_cnt, rx_cnt_nx, tx_cnt, tx_cnt_nx;

  // ---------------- address decode ----------------
  assign dlab    = lcr_q[DLAB];
  assign wr_data = host_wr && host_addr == OFS_DATA && !dlab;
  assign wr_dll  = host_wr && host_addr == OFS_DATA && dlab;
  assign wr_ier  = host_wr && host_addr == OFS_IEN && !dlab;
  assign wr_dlm  = host_wr && host_addr == OFS_IEN && dlab;
  assign wr_bc   = host_wr && host_addr == OFS_IDENT;
  assign wr_lcr  = host_wr && host_addr == OFS_LINE;
  assign wr_mcr  = host_wr && host_addr == OFS_MODEM;
  assign wr_scr  = host_wr && host_addr == OFS_SCRATCH;
  assign rd_data = host_rd && host_addr == OFS_DATA && !dlab;
  assign rd_lsr  = host_rd && host_addr == OFS_LSTAT;
  assign rd_msr  = host_rd && host_addr == OFS_MSTAT;

  // ---------------- buffer control ----------------
  assign mode_chg    = wr_bc && (host_wdata[BC_EN] != fen_q);
  assign rx_flush    = wr_bc && (host_wdata[BC_RXRST] || mode_chg);
  assign tx_flush    = wr_bc && (host_wdata[BC_TXRST] || mode_chg);
  assign rx_push_eff = rx_push && !rx_flush;
  assign rx_drop     = rx_push_eff && rx_full;

  // ---------------- next state ----------------
  always_comb begin
    msr_d = (rd_msr ? '0 : msr_q) | msr_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll_q  <= '0;
      dlm_q  <= '0;
      ier_q  <= '0;
      lcr_q  <= LINE_RESET;
      mcr_q  <= '0;
      scr_q  <= '0;
      msr_q  <= '0;
      fen_q  <= 1'b0;
      trig_q <= '0;
    end else begin
      if (wr_dll) dll_q <= host_wdata;
      if (wr_dlm) dlm_q <= host_wdata;
      if (wr_ier) ier_q <= host_wdata[IEN_W-1:0];
      if (wr_lcr) lcr_q <= host_wdata;
      if (wr_mcr) mcr_q <= host_wdata[MODEM_W-1:0];
      if (wr_scr) scr_q <= host_wdata;
      if (wr_bc) begin
        fen_q  <= host_wdata[BC_EN];
        trig_q <= host_wdata[7:6];
      end
      msr_q <= msr_d;
    end
  end

  // ---------------- buffers ----------------
  uart_regs_fifo #(.DW(RXW), .DEPTH(FIFO_DEPTH), .OVERWRITE(1'b0)) u_rx_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .deep     (fen_q),
    .flush    (rx_flush),
    .push     (rx_push_eff),
    .pop      (rd_data),
    .hd_clr   (1'b1),
    .hd_mask  ({{$bits(rx_flags_t){1'b0}}, {BYTE_W{1'b1}}}),
    .wdata    ({rx_err, rx_char}),
    .head     (rx_head),
    .count    (rx_cnt),
    .count_nx (rx_cnt_nx),
    .full     (rx_full)
  );

  uart_regs_fifo #(.DW(BYTE_W), .DEPTH(FIFO_DEPTH), .OVERWRITE(1'b1)) u_tx_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .deep     (fen_q),
    .flush    (tx_flush),
    .push     (wr_data),
    .pop      (tx_pop),
    .hd_clr   (1'b0),
    .hd_mask  ({BYTE_W{1'b1}}),
    .wdata    (host_wdata),
    .head     (tx_head),
    .count    (tx_cnt),
    .count_nx (tx_cnt_nx),
    .full     (tx_full)
  );

  uart_regs_lsr #(.CW(CW)) u_lsr (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_lsr        (rd_lsr),
    .rx_push       (rx_push_eff),
    .rx_drop       (rx_drop),
    .rx_flush      (rx_flush),
    .rx_cnt_nx     (rx_cnt_nx),
    .rx_head_valid (rx_cnt != '0),
    .rx_head_err   (rx_head[RXW-1:BYTE_W]),
    .tx_write      (wr_data),
    .tx_cnt_nx     (tx_cnt_nx),
    .tx_idle       (tx_idle),
    .lsr_o         (lsr_o)
  );

  // ---------------- read mux ----------------
  always_comb begin
    unique case (host_addr)
      OFS_DATA:    host_rdata = dlab ? dll_q : ((rx_cnt != '0) ? rx_head[BYTE_W-1:0] : '0);
      OFS_IEN:     host_rdata = dlab ? dlm_q : {{(BYTE_W-IEN_W){1'b0}}, ier_q};
      OFS_IDENT:   host_rdata = {2'b11, 2'b00, irq_id};
      OFS_LINE:    host_rdata = lcr_q;
      OFS_MODEM:   host_rdata = {{(BYTE_W-MODEM_W){1'b0}}, mcr_q};
      OFS_LSTAT:   host_rdata = lsr_o;
      OFS_MSTAT:   host_rdata = msr_q;
      default:     host_rdata = scr_q;
    endcase
  end

  assign rx_level  = rx_cnt;
  assign rx_read   = rd_data;
  assign tx_data   = tx_head;
  assign tx_avail  = (tx_cnt != '0);
  assign ier_o     = ier_q;
  assign lcr_o     = lcr_q;
  assign mcr_o     = mcr_q;
  assign divisor_o = {dlm_q, dll_q};
  assign fifo_en_o = fen_q;
  assign rx_trig_o = trig_q;

  p_dlab_keeps_ier_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == OFS_IEN && dlab) |=> $stable(ier_q));

  p_msr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && msr_set == '0) |=> msr_q == '0);

  p_flush_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> rx_level == '0);

  p_tx_overwrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_full && !tx_pop) |=> tx_cnt == $past(tx_cnt));

endmodule

// File: tb/uart_regs_tb.sv
module uart_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, host_rd;
  logic [2:0]  host_addr;
  logic [7:0]  host_wdata, host_rdata;
  logic        rx_push;
  logic [7:0]  rx_char;
  logic [2:0]  rx_err;
  logic [4:0]  rx_level;
  logic        rx_read;
  logic        tx_pop, tx_idle;
  logic [7:0]  tx_data;
  logic        tx_avail;
  logic [3:0]  irq_id;
  logic [7:0]  msr_set, lsr_o, lcr_o;
  logic [3:0]  ier_o;
  logic [4:0]  mcr_o;
  logic [15:0] divisor_o;
  logic        fifo_en_o;
  logic [1:0]  rx_trig_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic rd_seen;

  always #4 clk = ~clk;

  uart_regs u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_push(rx_push), .rx_char(rx_char), .rx_err(rx_err), .rx_level(rx_level),
    .rx_read(rx_read), .tx_pop(tx_pop), .tx_idle(tx_idle), .tx_data(tx_data),
    .tx_avail(tx_avail), .irq_id(irq_id), .msr_set(msr_set), .lsr_o(lsr_o),
    .ier_o(ier_o), .lcr_o(lcr_o), .mcr_o(mcr_o), .divisor_o(divisor_o),
    .fifo_en_o(fifo_en_o), .rx_trig_o(rx_trig_o)
  );

  // {is_read, offset, write data, expected read data}
  localparam int NV = 20;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd7, 8'hA5, 8'h00}, {1'b1, 3'd7, 8'h00, 8'hA5},
    {1'b0, 3'd5, 8'hFF, 8'h00}, {1'b1, 3'd5, 8'h00, 8'h60},
    {1'b0, 3'd6, 8'hFF, 8'h00}, {1'b1, 3'd6, 8'h00, 8'h00},
    {1'b0, 3'd1, 8'hFF, 8'h00}, {1'b1, 3'd1, 8'h00, 8'h0F},
    {1'b0, 3'd3, 8'h83, 8'h00}, {1'b0, 3'd0, 8'h34, 8'h00},
    {1'b0, 3'd1, 8'h12, 8'h00}, {1'b1, 3'd0, 8'h00, 8'h34},
    {1'b1, 3'd1, 8'h00, 8'h12}, {1'b1, 3'd3, 8'h00, 8'h83},
    {1'b0, 3'd3, 8'h03, 8'h00}, {1'b1, 3'd1, 8'h00, 8'h0F},
    {1'b1, 3'd0, 8'h00, 8'h00}, {1'b1, 3'd2, 8'h00, 8'hC6},
    {1'b0, 3'd4, 8'hFF, 8'h00}, {1'b1, 3'd4, 8'h00, 8'h1F}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #2;
    d = host_rdata;
    rd_seen = rx_read;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic rpush(input logic [7:0] c, input logic [2:0] e);
    @(negedge clk);
    rx_push = 1'b1; rx_char = c; rx_err = e;
    @(negedge clk);
    rx_push = 1'b0; rx_err = 3'b000;
  endtask

  task automatic tpop();
    @(negedge clk);
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0, 3'd1, 3'd3: return "R1";
      3'd2:             return "R8";
      default:          return "R11";
    endcase
  endfunction

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
    rx_push = 0; rx_char = 0; rx_err = 0; tx_pop = 0; tx_idle = 1'b1;
    irq_id = 4'h6; msr_set = 8'h00; rd_seen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    chk("R2 lcr", lcr_o, 8'h03);
    chk("R2 lsr", lsr_o, 8'h60);
    chk("R2 rx_level", rx_level, 0);
    chk("R2 tx_avail", tx_avail, 0);
    chk("R2 divisor", divisor_o, 0);
    chk("R2 fifo_en", fifo_en_o, 0);
    chk("R2 ier", ier_o, 0);

    // register table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) begin
        hread(VEC[i][18:16], v);
        chk(tag_of(VEC[i][18:16]), v, VEC[i][7:0]);
      end else begin
        hwrite(VEC[i][18:16], VEC[i][15:8]);
      end
    end
    chk("R1 divisor", divisor_o, 16'h1234);
    chk("R1 no tx from divisor write", tx_avail, 0);

    // R5 / R12 one-deep transmit
    hwrite(3'd0, 8'h41);
    chk("R5 tx_avail", tx_avail, 1);
    chk("R5 tx_data", tx_data, 8'h41);
    chk("R5 empties cleared", lsr_o[6:5], 2'b00);
    hwrite(3'd0, 8'h42);
    chk("R5 overwrite data", tx_data, 8'h42);
    chk("R5 overwrite count", tx_avail, 1);
    tx_idle = 1'b0;
    tpop();
    chk("R12 thre set", lsr_o[5], 1);
    chk("R12 temt waits idle", lsr_o[6], 0);
    tx_idle = 1'b1;
    @(negedge clk);
    chk("R12 temt set", lsr_o[6], 1);

    // R3 / R6 / R9 deep receive
    hwrite(3'd2, 8'hC1);
    chk("R3 fifo_en", fifo_en_o, 1);
    chk("R4 trigger", rx_trig_o, 2'b11);
    for (int i = 0; i < 16; i++) rpush(8'h10 + 8'(i), 3'b000);
    chk("R3 deep level", rx_level, 16);
    chk("R6 dr", lsr_o[0], 1);
    rpush(8'hEE, 3'b000);
    chk("R6 drop level", rx_level, 16);
    chk("R6 overrun", {lsr_o[7], lsr_o[1]}, 2'b11);
    hread(3'd5, v);
    chk("R7 lsr read value", v[1], 1);
    chk("R7 lsr cleared", {lsr_o[7], lsr_o[4:1]}, 0);
    chk("R7 dr kept", lsr_o[0], 1);
    for (int i = 0; i < 16; i++) begin
      hread(3'd0, v);
      chk("R9 order", v, 8'h10 + 8'(i));
    end
    chk("R9 rx_read pulse", rd_seen, 1);
    chk("R9 dr cleared", lsr_o[0], 0);
    chk("R9 empty level", rx_level, 0);
    hread(3'd0, v);
    chk("R9 empty read", v, 0);

    // R10 head flag merge
    rpush(8'h5A, 3'b010);
    @(negedge clk);
    chk("R10 framing merged", {lsr_o[7], lsr_o[3]}, 2'b11);
    hread(3'd5, v);
    chk("R10 lsr shows framing", v[3], 1);
    repeat (3) @(negedge clk);
    chk("R10 not re-merged", {lsr_o[7], lsr_o[3]}, 2'b00);
    hread(3'd0, v);
    chk("R10 char", v, 8'h5A);
    rpush(8'h33, 3'b101);
    @(negedge clk);
    chk("R10 break+parity", lsr_o & 8'h94, 8'h94);
    hread(3'd5, v);
    hread(3'd0, v);
    chk("R10 char2", v, 8'h33);

    // R4 individual flushes
    rpush(8'h01, 3'b000);
    rpush(8'h02, 3'b000);
    hwrite(3'd0, 8'h77);
    hwrite(3'd0, 8'h78);
    hwrite(3'd2, 8'h03);
    chk("R4 rx flushed", rx_level, 0);
    chk("R4 dr cleared", lsr_o[0], 0);
    chk("R4 tx kept", tx_avail, 1);
    hwrite(3'd2, 8'h05);
    chk("R4 tx flushed", tx_avail, 0);
    chk("R4 mode kept", fifo_en_o, 1);

    // R3 mode change flushes both
    rpush(8'h09, 3'b000);
    hwrite(3'd0, 8'h99);
    hwrite(3'd2, 8'h00);
    chk("R3 rx flushed", rx_level, 0);
    chk("R3 tx flushed", tx_avail, 0);
    chk("R3 dr cleared", lsr_o[0], 0);
    chk("R3 mode off", fifo_en_o, 0);
    rpush(8'hA1, 3'b000);
    rpush(8'hA2, 3'b000);
    chk("R3 one-deep level", rx_level, 1);
    chk("R3 one-deep overrun", lsr_o[1], 1);
    hread(3'd0, v);
    chk("R3 one-deep char", v, 8'hA1);

    // R7 modem status
    @(negedge clk); msr_set = 8'h0B;
    @(negedge clk); msr_set = 8'h00;
    hread(3'd6, v);
    chk("R7 msr value", v, 8'h0B);
    hread(3'd6, v);
    chk("R7 msr cleared", v, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule